// File: doc/BRIEF.md
# Inter-Cluster Result Router with Receiver Blocking

This block sits between the writeback stage and the decode stage of an in-order processor built from four clusters. Each cluster has its own 16-entry register file with one write port. Every cycle up to four issue slots each present a finished result. A result carries the index of the cluster that issued it, a 3-bit destination code, a 4-bit register number and the data. The code is relative to the issuing cluster. It expands to a 4-bit cluster mask that names one target, a pair of targets or all four. A crossbar routes each result to the write ports of the clusters in its mask. The write ports are registered, so a write is presented one cycle after the slot.

A result that lands in a cluster other than the one that issued it works as an implicit semaphore on the receiver. That cluster has a small state machine with two states, `BLK_IDLE` and `BLK_HELD`, and a 4-bit blocking field that holds the register being written from outside. It has three transitions:
- ARM (`BLK_IDLE` to `BLK_HELD`): a remote write wins the cluster's port.
- RELOAD (`BLK_HELD` to `BLK_HELD`): another remote write arrives while the field is held, and the field takes the new register.
- RELEASE (`BLK_HELD` to `BLK_IDLE`): no remote write arrives.

While a cluster is held, any decoding operand in that cluster that names the blocked register raises that cluster's stall line. When two or more slots aim at the same cluster in one cycle, the highest-numbered slot takes the port and a collision flag is raised beside the write.

Top module: `inter_cluster_router`

## Requirements
- R1: While reset is held and right after it, every write enable, collision flag and stall line is 0, even when valid operands name register 0.
- R2: Destination codes 0, 1, 2 and 3 (top bit 0) write only cluster 0, 1, 2 or 3, whatever the issuing cluster is.
- R3: Codes 4, 5 and 6 write the issuing cluster x and also cluster (x+1), (x+2) or (x+3) mod 4 respectively. No other cluster is written.
- R4: Code 7 writes all four clusters.
- R5: A slot presented in cycle t drives wr_en, wr_reg and wr_data of its target clusters in cycle t+1. A cycle with no valid slot produces no write.
- R6: When several valid slots target one cluster in the same cycle, the port carries the register and data of the highest-numbered slot, and wr_clash of that cluster is 1 in the write cycle. With a single writer, wr_clash is 0.
- R7: When the winning writer of cluster c comes from another cluster, cluster c is held during the write cycle. Its stall line is 1 exactly when read operand A or B of cluster c is valid and names the written register. A local winner causes no stall.
- R8: With no new remote write, the hold is released one cycle later, and the stall line is 0 for the same operands.
- R9: A read operand whose valid bit is 0 never stalls, even when its register matches the blocked one.
- R10: A remote write that arrives while a cluster is held replaces the blocked register. The old register no longer stalls and the new one does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_vld | input | N_SLOT | Result valid per issue slot |
| slot_src | input | N_SLOT x 2 | Issuing cluster per slot |
| slot_code | input | N_SLOT x 3 | Relative destination code per slot |
| slot_reg | input | N_SLOT x REG_W | Destination register per slot |
| slot_data | input | N_SLOT x DATA_W | Result data per slot |
| rd_vld_a | input | 4 | Operand A valid per cluster (decode) |
| rd_reg_a | input | 4 x REG_W | Operand A register per cluster |
| rd_vld_b | input | 4 | Operand B valid per cluster |
| rd_reg_b | input | 4 x REG_W | Operand B register per cluster |
| wr_en | output | 4 | Write enable per cluster port |
| wr_reg | output | 4 x REG_W | Written register per cluster |
| wr_data | output | 4 x DATA_W | Written data per cluster |
| wr_clash | output | 4 | Several slots competed for this port |
| stall | output | 4 | Decode stall per cluster |

## Verification
Port arbitration and receiver blocking can act on the same cluster in the same cycle. Several slots, drawn from a pseudo-random sweep of sources and codes, can collide on one cluster, and the winner alone must decide whether the cluster is held and which register stalls. The bench computes the expected winner, collision flag and stall for every cluster from the mask arithmetic. It then checks those against the ports in the write cycle, again with the operand valids cleared, and once more a cycle later. A directed sequence overlaps a new remote write with a live hold to judge RELOAD against RELEASE.

// File: rtl/icr_pkg.sv
package icr_pkg;
    localparam int CL_N   = 4;
    localparam int CL_W   = 2;
    localparam int CODE_W = 3;

    typedef enum logic [0:0] {
        BLK_IDLE = 1'b0,
        BLK_HELD = 1'b1
    } blk_state_e;
endpackage

// File: rtl/icr_dest_expand.sv
module icr_dest_expand
    import icr_pkg::*;
(
    input  logic [CL_W-1:0]   src_cl,
    input  logic [CODE_W-1:0] code,
    output logic [CL_N-1:0]   mask
);
    logic [CL_W-1:0] peer;

    // partner cluster for the pair codes, wrapping modulo the cluster count
    assign peer = src_cl + (code[CL_W-1:0] + CL_W'(1));

    always_comb begin
        mask = '0;
        unique case (code)
            3'd0, 3'd1, 3'd2, 3'd3: mask[code[CL_W-1:0]] = 1'b1;
            3'd4, 3'd5, 3'd6: begin
                mask[src_cl] = 1'b1;
                mask[peer]   = 1'b1;
            end
            default: mask = '1;
        endcase
    end

    always_comb begin
        p_unicast_single_r2: assert (code[2] || ($countones(mask) == 1));
        p_pair_has_local_r3: assert (!(code[2] && code != 3'd7) ||
                                     (($countones(mask) == 2) && mask[src_cl]));
        p_broadcast_all_r4:  assert ((code != 3'd7) || (mask == '1));
    end
endmodule

// File: rtl/icr_xbar.sv
module icr_xbar
    import icr_pkg::*;
#(
    parameter int N_SLOT = 4,
    parameter int REG_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_SLOT-1:0]               vld,
    input  logic [N_SLOT-1:0][CL_W-1:0]     src,
    input  logic [N_SLOT-1:0][CL_N-1:0]     mask,
    input  logic [N_SLOT-1:0][REG_W-1:0]    dreg,
    input  logic [N_SLOT-1:0][DATA_W-1:0]   data,
    output logic [CL_N-1:0]                 arm,
    output logic [CL_N-1:0][REG_W-1:0]      arm_reg,
    output logic [CL_N-1:0]                 wr_en,
    output logic [CL_N-1:0][REG_W-1:0]      wr_reg,
    output logic [CL_N-1:0][DATA_W-1:0]     wr_data,
    output logic [CL_N-1:0]                 wr_clash
);
    localparam int SL_W  = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;
    localparam int CNT_W = $clog2(N_SLOT + 1);

    for (genvar c = 0; c < CL_N; c++) begin : g_port
        logic [CNT_W-1:0]  hits;
        logic [SL_W-1:0]   win;
        logic              any;
        logic              en_q, clash_q;
        logic [REG_W-1:0]  reg_q;
        logic [DATA_W-1:0] data_q;

        // later slots overwrite earlier ones: highest-numbered slot wins
        always_comb begin
            hits = '0;
            win  = '0;
            any  = 1'b0;
            for (int s = 0; s < N_SLOT; s++) begin
                if (vld[s] && mask[s][c]) begin
                    hits = hits + CNT_W'(1);
                    win  = SL_W'(s);
                    any  = 1'b1;
                end
            end
        end

        assign arm[c]     = any && (src[win] != CL_W'(c));
        assign arm_reg[c] = dreg[win];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q    <= 1'b0;
                clash_q <= 1'b0;
                reg_q   <= '0;
                data_q  <= '0;
            end else begin
                en_q    <= any;
                clash_q <= (hits > CNT_W'(1));
                if (any) begin
                    reg_q  <= dreg[win];
                    data_q <= data[win];
                end
            end
        end

        assign wr_en[c]    = en_q;
        assign wr_clash[c] = clash_q;
        assign wr_reg[c]   = reg_q;
        assign wr_data[c]  = data_q;
    end
endmodule

// File: rtl/icr_block_fsm.sv
module icr_block_fsm
    import icr_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [REG_W-1:0] arm_reg,
    input  logic             rd_vld_a,
    input  logic [REG_W-1:0] rd_reg_a,
    input  logic             rd_vld_b,
    input  logic [REG_W-1:0] rd_reg_b,
    output logic             held,
    output logic [REG_W-1:0] blk_reg,
    output logic             stall
);
    blk_state_e       st_q, st_nx;
    logic [REG_W-1:0] blk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BLK_IDLE;
            blk_q <= '0;
        end else begin
            st_q <= st_nx;
            if (arm) blk_q <= arm_reg;
        end
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            BLK_IDLE: if (arm)  st_nx = BLK_HELD;  // ARM
            BLK_HELD: if (!arm) st_nx = BLK_IDLE;  // RELEASE, else RELOAD
            default:            st_nx = BLK_IDLE;
        endcase
    end

    always_comb begin
        held    = (st_q == BLK_HELD);
        blk_reg = blk_q;
        stall   = held && ((rd_vld_a && (rd_reg_a == blk_q)) ||
                           (rd_vld_b && (rd_reg_b == blk_q)));
    end
endmodule

// File: rtl/inter_cluster_router.sv
module inter_cluster_router
    import icr_pkg::*;
#(
    parameter int N_SLOT = 4,
    parameter int REG_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SLOT-1:0]             slot_vld,
    input  logic [N_SLOT-1:0][1:0]        slot_src,
    input  logic [N_SLOT-1:0][2:0]        slot_code,
    input  logic [N_SLOT-1:0][REG_W-1:0]  slot_reg,
    input  logic [N_SLOT-1:0][DATA_W-1:0] slot_data,
    input  logic [3:0]                    rd_vld_a,
    input  logic [3:0][REG_W-1:0]         rd_reg_a,
    input  logic [3:0]                    rd_vld_b,
    input  logic [3:0][REG_W-1:0]         rd_reg_b,
    output logic [3:0]                    wr_en,
    output logic [3:0][REG_W-1:0]         wr_reg,
    output logic [3:0][DATA_W-1:0]        wr_data,
    output logic [3:0]                    wr_clash,
    output logic [3:0]                    stall
);
    logic [N_SLOT-1:0][CL_N-1:0] slot_mask;
    logic [CL_N-1:0]             arm;
    logic [CL_N-1:0][REG_W-1:0]  arm_reg;
    logic [CL_N-1:0]             held;
    logic [CL_N-1:0][REG_W-1:0]  blk_reg;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        icr_dest_expand u_exp (
            .src_cl (slot_src[s]),
            .code   (slot_code[s]),
            .mask   (slot_mask[s])
        );
    end

    icr_xbar #(.N_SLOT(N_SLOT), .REG_W(REG_W), .DATA_W(DATA_W)) u_xbar (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (slot_vld),
        .src      (slot_src),
        .mask     (slot_mask),
        .dreg     (slot_reg),
        .data     (slot_data),
        .arm      (arm),
        .arm_reg  (arm_reg),
        .wr_en    (wr_en),
        .wr_reg   (wr_reg),
        .wr_data  (wr_data),
        .wr_clash (wr_clash)
    );

    for (genvar c = 0; c < CL_N; c++) begin : g_blk
        icr_block_fsm #(.REG_W(REG_W)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm      (arm[c]),
            .arm_reg  (arm_reg[c]),
            .rd_vld_a (rd_vld_a[c]),
            .rd_reg_a (rd_reg_a[c]),
            .rd_vld_b (rd_vld_b[c]),
            .rd_reg_b (rd_reg_b[c]),
            .held     (held[c]),
            .blk_reg  (blk_reg[c]),
            .stall    (stall[c])
        );

        p_write_has_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[c] |-> $past(|slot_vld));
        p_clash_with_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
            wr_clash[c] |-> wr_en[c]);
        p_held_matches_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
            held[c] |-> (wr_en[c] && (wr_reg[c] == blk_reg[c])));
        p_stall_only_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
            stall[c] |-> wr_en[c]);
        p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (held[c] && !arm[c]) |=> !held[c]);
    end
endmodule

// File: tb/inter_cluster_router_tb.sv
module inter_cluster_router_tb;
    localparam int CLK_P  = 10;
    localparam int N_SLOT = 4;
    localparam int REG_W  = 4;
    localparam int DATA_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_SLOT-1:0]             slot_vld = '0;
    logic [N_SLOT-1:0][1:0]        slot_src = '0;
    logic [N_SLOT-1:0][2:0]        slot_code = '0;
    logic [N_SLOT-1:0][REG_W-1:0]  slot_reg = '0;
    logic [N_SLOT-1:0][DATA_W-1:0] slot_data = '0;
    logic [3:0]                    rd_vld_a = '0, rd_vld_b = '0;
    logic [3:0][REG_W-1:0]         rd_reg_a = '0, rd_reg_b = '0;
    logic [3:0]                    wr_en, wr_clash, stall;
    logic [3:0][REG_W-1:0]         wr_reg;
    logic [3:0][DATA_W-1:0]        wr_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [31:0] lf = 32'h1357_9bdf;

    int e_win[4];
    int e_hits[4];
    bit e_any[4];
    bit e_held[4];

    always #(CLK_P/2) clk = ~clk;

    inter_cluster_router #(.N_SLOT(N_SLOT), .REG_W(REG_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .slot_vld(slot_vld), .slot_src(slot_src), .slot_code(slot_code),
        .slot_reg(slot_reg), .slot_data(slot_data),
        .rd_vld_a(rd_vld_a), .rd_reg_a(rd_reg_a), .rd_vld_b(rd_vld_b), .rd_reg_b(rd_reg_b),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data), .wr_clash(wr_clash), .stall(stall)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] rnd();
        lf = lf ^ (lf << 13);
        lf = lf ^ (lf >> 17);
        lf = lf ^ (lf << 5);
        return lf;
    endfunction

    // R2/R3/R4: mask arithmetic from the code table
    function automatic logic [3:0] exp_mask(input int x, input int code);
        if (code < 4)  return 4'(1 << code);
        if (code == 7) return 4'hf;
        return 4'((1 << x) | (1 << ((x + code - 3) % 4)));
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string code_req(input int code);
        if (code < 4)  return "R2";
        if (code == 7) return "R4";
        return "R3";
    endfunction

    // caller sets slot inputs just after a negedge; this checks the write cycle and the release
    task automatic apply_and_check(input string req_tag);
        for (int c = 0; c < 4; c++) begin
            e_any[c] = 0; e_hits[c] = 0; e_win[c] = 0;
            for (int s = 0; s < N_SLOT; s++) begin
                if (slot_vld[s] && exp_mask(int'(slot_src[s]), int'(slot_code[s]))[c]) begin
                    e_any[c] = 1; e_hits[c]++; e_win[c] = s;
                end
            end
            e_held[c] = e_any[c] && (int'(slot_src[e_win[c]]) != c);
        end
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            logic [31:0] r = rnd();
            rd_reg_a[c] = r[0] ? slot_reg[e_win[c]] : r[7:4];
            rd_reg_b[c] = r[11:8];
            rd_vld_a[c] = r[1] | r[2];
            rd_vld_b[c] = r[3];
        end
        slot_vld = '0;
        #1;
        for (int c = 0; c < 4; c++) begin
            bit hit;
            hit = e_held[c] &&
                  ((rd_vld_a[c] && rd_reg_a[c] == slot_reg[e_win[c]]) ||
                   (rd_vld_b[c] && rd_reg_b[c] == slot_reg[e_win[c]]));
            chk(req_tag, $sformatf("wr_en[%0d]", c), wr_en[c], e_any[c]);
            if (e_any[c]) begin
                chk(req_tag, $sformatf("wr_reg[%0d]", c), wr_reg[c], slot_reg[e_win[c]]);
                chk(req_tag, $sformatf("wr_data[%0d]", c), wr_data[c], slot_data[e_win[c]]);
            end
            chk("R6", $sformatf("wr_clash[%0d]", c), wr_clash[c], e_hits[c] > 1);
            chk("R7", $sformatf("stall[%0d]", c), stall[c], hit);
        end
        begin
            logic [3:0] sa = rd_vld_a, sb = rd_vld_b;
            rd_vld_a = '0; rd_vld_b = '0;
            #1;
            chk("R9", "stall with invalid reads", stall, 0);
            rd_vld_a = sa; rd_vld_b = sb;
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R8", "stall after release", stall, 0);
        chk("R5", "no write without slots", wr_en, 0);
    endtask

    initial begin
        // R1: reset state
        rd_vld_a = 4'hf; rd_vld_b = 4'hf;
        repeat (3) @(negedge clk);
        chk("R1", "wr_en in reset", wr_en, 0);
        chk("R1", "wr_clash in reset", wr_clash, 0);
        chk("R1", "stall in reset", stall, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "stall after reset", stall, 0);
        chk("R1", "wr_en after reset", wr_en, 0);
        rd_vld_a = '0; rd_vld_b = '0;

        // R2/R3/R4: every slot, source and code alone
        for (int s = 0; s < N_SLOT; s++) begin
            for (int x = 0; x < 4; x++) begin
                for (int code = 0; code < 8; code++) begin
                    slot_vld = '0;
                    slot_vld[s] = 1'b1;
                    slot_src[s] = 2'(x);
                    slot_code[s] = 3'(code);
                    slot_reg[s] = 4'(code + 3 * x + s);
                    slot_data[s] = {8'(s), 8'(x), 8'(code), 8'hA5};
                    apply_and_check(code_req(code));
                end
            end
        end

        // R6: all slots together, colliding on ports
        for (int t = 0; t < 500; t++) begin
            logic [31:0] r = rnd();
            for (int s = 0; s < N_SLOT; s++) begin
                logic [31:0] q = rnd();
                slot_src[s] = q[1:0];
                slot_code[s] = q[4:2];
                slot_reg[s] = q[8:5];
                slot_data[s] = q ^ 32'(t);
            end
            slot_vld = r[3:0] | 4'(t % 2);
            apply_and_check("R6");
        end

        // R10: remote write while the hold is live
        @(negedge clk);
        slot_vld = 4'b0001; slot_src[0] = 2'd0; slot_code[0] = 3'd1; slot_reg[0] = 4'd3;
        slot_data[0] = 32'h1111_0003;
        @(negedge clk);
        slot_reg[0] = 4'd5; slot_data[0] = 32'h1111_0005;
        rd_vld_a = 4'b0010; rd_reg_a[1] = 4'd3;
        rd_vld_b = 4'b0000; rd_reg_b[1] = 4'd5;
        #1;
        chk("R7", "stall on first blocked reg", stall[1], 1);
        @(negedge clk);
        slot_vld = '0;
        #1;
        chk("R10", "old reg after reload", stall[1], 0);
        chk("R10", "port reg after reload", wr_reg[1], 5);
        rd_vld_b = 4'b0010;
        #1;
        chk("R10", "new reg after reload", stall[1], 1);
        @(negedge clk);
        #1;
        chk("R8", "release after reload", stall[1], 0);
        rd_vld_a = '0; rd_vld_b = '0;

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule